// File: doc/BRIEF.md
# Trigger Hit Address Concentrator

This block gathers the coarse trigger bits of one detector chamber on every bunch crossing and turns them into a compact list of hit addresses. The chamber is read by 24 front-end chips arranged as 3 columns by 8 partitions. Each chip delivers 32 trigger bits, one per group of 4 strips. The whole chamber therefore arrives as one flat 768-bit vector, qualified by a crossing strobe.

Inside the vector, bit i belongs to chip i/32 and pad i%32. Chip c sits in column c/8 and partition c%8. The block finds the set bits, lowest first, and encodes each as a 10-bit address. It packs at most nine of them into a 96-bit frame, together with the number of hits and a flag that marks hits which did not fit. A frame leaves on every clock, a fixed two cycles after its input, with no stalls.

Top module: `trig_hit_concentrator`

## Requirements
- R1: A set input bit i is reported as the 10-bit address {column, partition, pad}: column = i/256 in bits 9:8, partition = (i/32)%8 in bits 7:5, pad = i%32 in bits 4:0. The address therefore equals i.
- R2: Reported hits fill the slots in ascending address order. Slot 0 holds the lowest set bit, and the slots that follow hold the next higher set bits in turn.
- R3: When more than nine bits are set, only the nine lowest are reported and frame bit 94 (overflow) is 1. Otherwise bit 94 is 0.
- R4: Frame bits 93:90 hold the number of reported hits, equal to the smaller of the set-bit count and 9.
- R5: Slot k occupies frame bits 10k+9:10k for k = 0..8. A slot without a hit holds 0x3FF, a code whose column field 3 no real address reaches.
- R6: Frame bit 95 is always 0.
- R7: The frame for a crossing appears exactly 2 clock cycles after the crossing's input is sampled. A new frame may be produced every cycle.
- R8: While rst_n is low at a clock edge, the next outputs are frame_valid = 0, all slots 0x3FF, count 0 and overflow 0.
- R9: A cycle with bx_strobe low yields frame_valid low 2 cycles later, whatever the trigger bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bx_strobe | input | 1 | Marks trig_bits as a valid crossing |
| trig_bits | input | 768 | Trigger bits of all chips, bit i as in R1 |
| frame_valid | output | 1 | Frame holds a crossing's result |
| frame | output | 96 | Packed slots, count, overflow, reserved bit |

## Verification
The assertions assume bx_strobe and trig_bits are stable around the rising edge and carry no X once reset is released. They also assume that the two-cycle valid relation is judged only after two edges out of reset. The stimulus drives every input on the falling edge only and holds rst_n low for several edges before any crossing. It mixes empty, single, exactly-nine, ten-plus and fully-set vectors with sparse random patterns and idle cycles, so that each slot and flag property is exercised with both outcomes.

// File: rtl/trig_hit_pkg.sv
// Package: geometry and frame layout of the hit concentrator.
// Assumes: column/partition/pad fields are contiguous, so address == bit index.
package trig_hit_pkg;
    localparam int NUM_COLS      = 3;
    localparam int NUM_PARTS     = 8;
    localparam int PADS_PER_CHIP = 32;
    localparam int NUM_CHIPS     = NUM_COLS * NUM_PARTS;
    localparam int TOTAL_BITS    = NUM_CHIPS * PADS_PER_CHIP;
    localparam int PAD_W         = $clog2(PADS_PER_CHIP);
    localparam int PART_W        = $clog2(NUM_PARTS);
    localparam int COL_W         = 2;
    localparam int ADDR_W        = COL_W + PART_W + PAD_W;
    localparam int MAX_HITS      = 9;
    localparam int COUNT_W       = 4;
    localparam int SLOTS_W       = MAX_HITS * ADDR_W;
    localparam int COUNT_LSB     = SLOTS_W;
    localparam int OVF_BIT       = COUNT_LSB + COUNT_W;
    localparam int FRAME_W       = 96;
    localparam logic [ADDR_W-1:0] EMPTY_SLOT = '1;
endpackage

// File: rtl/first_hit_finder.sv
// Module: first_hit_finder
// Finds the lowest set bit of a vector and returns its index.
// Assumes: index width can hold N-1.
module first_hit_finder #(
    parameter int N  = 768,
    parameter int AW = 10
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [AW-1:0] idx
);
    // Scan from the top so the lowest set bit is the final winner.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end
endmodule

// File: rtl/multi_hit_picker.sv
// Module: multi_hit_picker
// Chain of H lowest-bit finders; each stage clears the bit it took.
// Assumes: purely combinational, placed between two register stages.
module multi_hit_picker #(
    parameter int N  = 768,
    parameter int AW = 10,
    parameter int H  = 9
) (
    input  logic [N-1:0]    vec,
    output logic [H-1:0]    hit,
    output logic [H*AW-1:0] addr,
    output logic            overflow
);
    logic [N-1:0] remain [0:H];

    assign remain[0] = vec;

    generate
        for (genvar k = 0; k < H; k++) begin : g_pick
            logic          f;
            logic [AW-1:0] a;
            first_hit_finder #(.N(N), .AW(AW)) u_find (
                .vec   (remain[k]),
                .found (f),
                .idx   (a)
            );
            // Remove the chosen bit before the next stage looks.
            always_comb begin
                remain[k+1] = remain[k];
                if (f) remain[k+1][a] = 1'b0;
            end
            assign hit[k]               = f;
            assign addr[k*AW +: AW]     = a;
        end
    endgenerate

    // Any bit left after H picks means hits were dropped.
    assign overflow = |remain[H];
endmodule

// File: rtl/frame_packer.sv
// Module: frame_packer
// Registers the picked hits into the output frame with count and overflow.
// Assumes: hit flags are contiguous from slot 0 (guaranteed by the picker).
module frame_packer
    import trig_hit_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [MAX_HITS-1:0]    hit,
    input  logic [SLOTS_W-1:0]     addr,
    input  logic                   overflow,
    output logic                   frame_valid,
    output logic [FRAME_W-1:0]     frame
);
    logic [FRAME_W-1:0] next_frame;
    logic [COUNT_W-1:0] count;

    // Count reported hits.
    always_comb begin
        count = '0;
        for (int k = 0; k < MAX_HITS; k++) count = count + COUNT_W'(hit[k]);
    end

    // Assemble slots, count, overflow and reserved bit.
    always_comb begin
        next_frame = '0;
        for (int k = 0; k < MAX_HITS; k++)
            next_frame[k*ADDR_W +: ADDR_W] = hit[k] ? addr[k*ADDR_W +: ADDR_W] : EMPTY_SLOT;
        next_frame[COUNT_LSB +: COUNT_W] = count;
        next_frame[OVF_BIT]              = overflow;
    end

    // Output register; reset leaves an empty frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            frame       <= FRAME_W'({MAX_HITS{EMPTY_SLOT}});
        end else begin
            frame_valid <= in_valid;
            frame       <= next_frame;
        end
    end
endmodule

// File: rtl/trig_hit_concentrator.sv
// Module: trig_hit_concentrator
// Two-stage fixed-latency concentrator: input capture, then pick and pack.
// Assumes: trig_bits bit i is pad i%32 of chip i/32, chip c = column c/8, partition c%8.
module trig_hit_concentrator
    import trig_hit_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bx_strobe,
    input  logic [TOTAL_BITS-1:0] trig_bits,
    output logic                  frame_valid,
    output logic [FRAME_W-1:0]    frame
);
    logic                  cap_valid;
    logic [TOTAL_BITS-1:0] cap_bits;
    logic [MAX_HITS-1:0]   pick_hit;
    logic [SLOTS_W-1:0]    pick_addr;
    logic                  pick_ovf;

    // Stage 1: capture the crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            cap_bits  <= '0;
        end else begin
            cap_valid <= bx_strobe;
            cap_bits  <= trig_bits;
        end
    end

    multi_hit_picker #(.N(TOTAL_BITS), .AW(ADDR_W), .H(MAX_HITS)) u_pick (
        .vec      (cap_bits),
        .hit      (pick_hit),
        .addr     (pick_addr),
        .overflow (pick_ovf)
    );

    frame_packer u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (cap_valid),
        .hit         (pick_hit),
        .addr        (pick_addr),
        .overflow    (pick_ovf),
        .frame_valid (frame_valid),
        .frame       (frame)
    );
endmodule

// File: rtl/trig_hit_checker.sv
// Module: trig_hit_checker
// Port-level properties of the concentrator frame.
// Assumes: inputs are known and stable at the rising edge after reset.
module trig_hit_checker
    import trig_hit_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bx_strobe,
    input logic               frame_valid,
    input logic [FRAME_W-1:0] frame
);
    logic [1:0]         since_rst;
    logic [COUNT_W-1:0] cnt;

    assign cnt = frame[COUNT_LSB +: COUNT_W];

    // Edges since reset release, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst == 2'd2 |-> frame_valid == $past(bx_strobe, 2));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && !$past(bx_strobe, 2)) |-> !frame_valid);

    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (!frame_valid && cnt == '0 && !frame[OVF_BIT]
                    && frame[SLOTS_W-1:0] == {MAX_HITS{EMPTY_SLOT}}));

    p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> !frame[FRAME_W-1]);

    p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> cnt <= COUNT_W'(MAX_HITS));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame[OVF_BIT]) |-> cnt == COUNT_W'(MAX_HITS));

    generate
        for (genvar j = 0; j < MAX_HITS; j++) begin : g_slot
            p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (frame_valid && cnt <= COUNT_W'(j)) |-> frame[j*ADDR_W +: ADDR_W] == EMPTY_SLOT);
            p_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (frame_valid && cnt > COUNT_W'(j)) |-> frame[j*ADDR_W + ADDR_W - 1 -: COL_W] != 2'd3);
            if (j > 0) begin : g_ord
                p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    (frame_valid && cnt > COUNT_W'(j)) |->
                    frame[j*ADDR_W +: ADDR_W] > frame[(j-1)*ADDR_W +: ADDR_W]);
            end
        end
    endgenerate
endmodule

bind trig_hit_concentrator trig_hit_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bx_strobe   (bx_strobe),
    .frame_valid (frame_valid),
    .frame       (frame)
);

// File: tb/sim_trig_hit_concentrator.sv
// Bench: scoreboard for trig_hit_concentrator.
// Driver pushes expected frames tagged with their due cycle; monitor compares.
module sim_trig_hit_concentrator;
    import trig_hit_pkg::*;

    typedef struct {
        int               due;
        bit               v;
        logic [FRAME_W-1:0] f;
        string            req;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bx_strobe = 1'b0;
    logic [TOTAL_BITS-1:0] trig_bits = '0;
    logic                  frame_valid;
    logic [FRAME_W-1:0]    frame;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trig_hit_concentrator u0 (
        .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe),
        .trig_bits(trig_bits), .frame_valid(frame_valid), .frame(frame)
    );

    // Expected frame from the requirements (R1..R6).
    function automatic logic [FRAME_W-1:0] model(input logic [TOTAL_BITS-1:0] v);
        logic [FRAME_W-1:0] f;
        int n;
        f = '0;
        n = 0;
        for (int k = 0; k < MAX_HITS; k++) f[k*ADDR_W +: ADDR_W] = 10'h3FF;
        for (int i = 0; i < TOTAL_BITS; i++) begin
            if (v[i]) begin
                if (n < MAX_HITS) begin
                    f[n*ADDR_W +: ADDR_W] = {2'(i / 256), 3'((i / 32) % 8), 5'(i % 32)};
                    n++;
                end else begin
                    f[94] = 1'b1;
                end
            end
        end
        f[93:90] = 4'(n);
        return f;
    endfunction

    task automatic check(input string req, input bit ok, input logic [FRAME_W-1:0] act,
                         input logic [FRAME_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one crossing on the falling edge and queue its expectation.
    task automatic drive(input logic [TOTAL_BITS-1:0] v, input bit s, input string req);
        exp_t e;
        @(negedge clk);
        trig_bits = v;
        bx_strobe = s;
        e.due = cyc + 2;
        e.v   = s;
        e.f   = model(v);
        e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: sample 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " valid"}, frame_valid == e.v, {95'd0, frame_valid}, {95'd0, e.v});
                if (e.v) check(e.req, frame == e.f, frame, e.f);
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [FRAME_W-1:0] empty_frame();
        return FRAME_W'({MAX_HITS{10'h3FF}});
    endfunction

    initial begin
        logic [TOTAL_BITS-1:0] v;
        // R8: reset state, even with a strobe and bits present.
        bx_strobe = 1'b1;
        trig_bits = '1;
        repeat (3) @(negedge clk);
        check("R8", !frame_valid && frame == empty_frame(), frame, empty_frame());

        @(negedge clk);
        rst_n = 1'b1;
        bx_strobe = 1'b0;

        drive('0, 1'b1, "R5 empty vector");
        v = '0; v[0] = 1'b1;
        drive(v, 1'b1, "R1 lowest bit");
        v = '0; v[767] = 1'b1;
        drive(v, 1'b1, "R1 highest bit");
        v = '0; v[300] = 1'b1; v[31] = 1'b1; v[32] = 1'b1; v[256] = 1'b1;
        drive(v, 1'b1, "R2 order across chips");
        v = '0;
        for (int i = 0; i < 9; i++) v[i * 85 + 3] = 1'b1;
        drive(v, 1'b1, "R4 exactly nine");
        v[700] = 1'b1;
        drive(v, 1'b1, "R3 ten hits overflow");
        drive('1, 1'b1, "R3 all set");
        drive('1, 1'b0, "R9 strobe low");
        v = '0; v[5] = 1'b1;
        drive(v, 1'b0, "R9 strobe low single");
        drive(v, 1'b1, "R7 after idle");

        // R7: back-to-back sparse random crossings.
        for (int t = 0; t < 60; t++) begin
            v = '0;
            for (int h = 0; h < int'($urandom_range(0, 13)); h++)
                v[$urandom_range(0, TOTAL_BITS - 1)] = 1'b1;
            drive(v, ($urandom_range(0, 4) != 0), "R7 stream");
        end
        drive('0, 1'b0, "R9 drain");
        repeat (4) @(negedge clk);

        // R8: reset in mid-run.
        v = '0; v[10] = 1'b1;
        trig_bits = v;
        bx_strobe = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 mid-run", !frame_valid && frame == empty_frame(), frame, empty_frame());
        rst_n = 1'b1;
        bx_strobe = 1'b0;
        drive(v, 1'b1, "R1 after reset");
        drive('0, 1'b0, "R9 final");
        repeat (4) @(negedge clk);

        check("R7 scoreboard drained", sb.size() == 0, FRAME_W'(sb.size()), '0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule